// File: doc/BRIEF.md
# SPI Slave Channel with Transmit Queue and Event Interrupts

This block is one serial-peripheral slave channel seen from a local host. The host loads outgoing bytes into a transmit queue and collects incoming bytes from a receive holding register. It does this through a four-address register port with a write strobe and a read strobe. An external SPI master clocks the bytes in and out in mode 0. Clock polarity is idle-low, data is sampled on the rising edge and changed on the falling edge, and words are 8 bits, most significant bit first. The serial inputs are brought into the system clock domain by two-stage synchronizers, so SCLK must run well below the system clock. The bench uses 16 system clocks per SCLK period.

Four conditions are tracked, each as its own sticky status bit:
- transmit-empty
- transmit-underflow
- receive-full
- receive-overflow

A single interrupt line is the OR of the status bits whose enable is set. In queue mode the transmit-empty event is a watermark event with a handshake. It fires once when enough room is free, and it fires again only after the host has delivered the programmed number of bytes.

Top module: `spis_irq_top`

## Requirements
- R1: Register map on `host_addr`. Address 0 is control: bit 0 is the channel enable, bit 1 is the queue enable and bits [8:4] are the watermark level. Address 1 is the interrupt enable mask, bits [3:0]. Address 2 is the status register, bits [3:0]: bit 0 is transmit-empty, bit 1 is transmit-underflow, bit 2 is receive-full and bit 3 is receive-overflow. Address 3 is written to load a transmit byte and read to return the receive register in bits [7:0]. Unused read bits are zero. After reset every register reads 0, and `irq` and `somi_oe` are 0.
- R2: With the queue disabled, transmit-empty is raised on every cycle in which the channel is enabled and the single transmit register is empty. Enabling the channel therefore raises it at once. It is never raised while the channel is disabled.
- R3: `irq` is high exactly while some status bit and its enable are both 1. Loading a transmit byte does not clear a pending status bit or drop `irq`; only a status clear does.
- R4: Writing 1 to a status bit clears it and writing 0 leaves it. If the event is present in the same cycle as the clear, the bit stays set.
- R5: While `cs_n` is low and the channel is enabled, `somi_oe` is 1. SIMO is captured on rising SCLK edges and SOMI changes on falling edges, MSB first. Otherwise `somi_oe` is 0.
- R6: When the eighth bit of a word has been captured, the word is placed in the receive register and receive-full is raised. Reading address 3 marks the word as read.
- R7: If a word completes while the previous one is still unread, receive-overflow is raised and the new word replaces the old one.
- R8: A byte is fetched for output when the chip is selected, and again on the falling SCLK edge that follows each completed word while still selected. If nothing is queued at a fetch, transmit-underflow is raised and the word sent is 0x00.
- R9: The queue holds 16 bytes, sent in write order, when enabled. With the queue disabled it holds a single byte. A write beyond the capacity is dropped and does not change what is sent.
- R10: With the queue enabled and the channel on, transmit-empty fires when the free space is at least the watermark level. A level of 0 counts as 1 and a level above 16 counts as 16.
- R11: In queue mode, after transmit-empty has fired it does not fire again until the host has made watermark-level accepted writes. A write in the firing cycle itself is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_re | input | 1 | Host read strobe, marks the receive word read at address 3 |
| host_addr | input | 2 | Register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Register read data, combinational on `host_addr` |
| sclk | input | 1 | Serial clock from the master (asynchronous) |
| simo | input | 1 | Serial data from the master |
| cs_n | input | 1 | Active-low chip select |
| somi | output | 1 | Serial data to the master |
| somi_oe | output | 1 | Output enable for `somi`; 0 means high impedance |
| irq | output | 1 | Interrupt request |

## Verification
The watermark arming state and the queue count are invisible at the ports. A wrong value in either shows up in two ways:
- transmit-empty may appear in the status register when it should not, or fail to appear once the host has made the required writes; this is visible one or two cycles after the write;
- the wrong bytes may come out on SOMI during the next transfer.

A bit counter out of step with the master shifts every later word by a bit and moves the receive-full event. An unread flag stuck in either state is exposed by the overflow bit after a second word. The bench therefore reads status after each host write, and compares every transferred byte against a queue model kept in the bench.

// File: rtl/spis_pkg.sv
package spis_pkg;
  // Register addresses on the host port
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_IEN  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  // Status bit positions
  localparam int EV_TXE = 0;
  localparam int EV_TXU = 1;
  localparam int EV_RXF = 2;
  localparam int EV_RXO = 3;
  localparam int N_EV   = 4;

  // Control field positions
  localparam int CTL_CHAN    = 0;
  localparam int CTL_QUEUE   = 1;
  localparam int CTL_LVL_LSB = 4;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/spis_txq.sv
module spis_txq #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          fifo_en,
  input  logic [CW-1:0] level_raw,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          ev_txe
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count, wcnt;
  logic          armed;
  logic [CW-1:0] cap, lvl, free;
  logic          push_ok, pop_ok;

  // Capacity: full depth in queue mode, one byte otherwise
  function automatic logic [CW-1:0] cap_of(input logic q_on);
    return q_on ? CW'(DEPTH) : CW'(1);
  endfunction

  // Watermark level clamped into 1..DEPTH
  function automatic logic [CW-1:0] lvl_of(input logic [CW-1:0] raw);
    if (raw == '0) return CW'(1);
    if (raw > CW'(DEPTH)) return CW'(DEPTH);
    return raw;
  endfunction

  function automatic logic [CW-1:0] free_of(input logic [CW-1:0] c, input logic [CW-1:0] k);
    return (k > c) ? (k - c) : '0;
  endfunction

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign cap     = cap_of(fifo_en);
  assign lvl     = lvl_of(level_raw);
  assign free    = free_of(count, cap);
  assign push_ok = push && (count < cap);
  assign pop_ok  = pop && (count != '0);
  assign empty   = (count == '0);
  assign head    = mem[rp];
  assign ev_txe  = chan_en && (fifo_en ? (armed && (free >= lvl)) : empty);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= next_ptr(wp);
      if (pop_ok)  rp <= next_ptr(rp);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  // Watermark handshake: one event, then wait for level accepted writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b1;
      wcnt  <= '0;
    end else if (!chan_en || !fifo_en) begin
      armed <= 1'b1;
      wcnt  <= '0;
    end else if (ev_txe) begin
      armed <= 1'b0;
      wcnt  <= '0;
    end else if (push_ok && !armed) begin
      if (wcnt + CW'(1) >= lvl) begin
        armed <= 1'b1;
        wcnt  <= '0;
      end else begin
        wcnt <= wcnt + CW'(1);
      end
    end
  end

  // R9: occupancy never exceeds the storage
  a_r9_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R9: a write at capacity without a read leaves occupancy unchanged
  a_r9_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && (count >= cap)) |=> $stable(count));

  // R11: a queue-mode event is never followed directly by another
  a_r11_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_txe && fifo_en && chan_en) |=> !(ev_txe && fifo_en && chan_en));
endmodule

// File: rtl/spis_shift.sv
module spis_shift #(
  parameter int DW  = 8,
  localparam int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          sclk_s,
  input  logic          simo_s,
  input  logic [DW-1:0] q_head,
  input  logic          q_empty,
  output logic          q_pop,
  output logic          somi,
  output logic          rx_done,
  output logic [DW-1:0] rx_word,
  output logic          ev_txu
);
  logic          sclk_d, cs_d;
  logic [BW-1:0] bcnt;
  logic [DW-1:0] tx_sh, rx_sh;
  logic          rise, fall, fetch;

  assign rise    = sclk_s & ~sclk_d;
  assign fall    = ~sclk_s & sclk_d;
  // Fetch on select, then on the falling edge that opens each new word
  assign fetch   = cs_act & (~cs_d | (fall & (bcnt == '0)));
  assign q_pop   = fetch;
  assign ev_txu  = fetch & q_empty;
  assign rx_word = {rx_sh[DW-2:0], simo_s};
  assign rx_done = cs_act & rise & (bcnt == BW'(DW - 1));
  assign somi    = tx_sh[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b0;
      bcnt   <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_act;
      if (!cs_act)   bcnt <= '0;
      else if (rise) bcnt <= (bcnt == BW'(DW - 1)) ? '0 : bcnt + BW'(1);
      if (cs_act && rise) rx_sh <= rx_word;
      if (fetch)               tx_sh <= q_empty ? '0 : q_head;
      else if (cs_act && fall) tx_sh <= {tx_sh[DW-2:0], 1'b0};
    end
  end

  // R8: a fetch from an empty queue sends all zeros
  a_r8_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && q_empty) |=> (tx_sh == '0));

  // R6: a completed word restarts the bit count
  a_r6_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> (bcnt == '0));
endmodule

// File: rtl/spis_evt.sv
module spis_evt
  import spis_pkg::*;
#(
  parameter int DW = 8,
  parameter int NE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_txe,
  input  logic          ev_txu,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_word,
  input  logic          rx_read,
  input  logic [NE-1:0] clr,
  input  logic [NE-1:0] ien,
  output logic [NE-1:0] status,
  output logic [DW-1:0] rx_hold,
  output logic          irq
);
  logic          unread;
  logic [NE-1:0] ev;

  always_comb begin
    ev         = '0;
    ev[EV_TXE] = ev_txe;
    ev[EV_TXU] = ev_txu;
    ev[EV_RXF] = rx_done;
    ev[EV_RXO] = rx_done & unread;
  end

  assign irq = |(status & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= '0;
      rx_hold <= '0;
      unread  <= 1'b0;
    end else begin
      status <= (status & ~clr) | ev;
      if (rx_done) begin
        rx_hold <= rx_word;
        unread  <= 1'b1;
      end else if (rx_read) begin
        unread <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NE; g++) begin : g_bit
    // R4: an event always lands, even against a clear
    a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
      ev[g] |=> status[g]);
    // R4: a bit holds until written with 1
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status[g] && !clr[g]) |=> status[g]);
    // R4: a clear without a coinciding event drops the bit
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (status[g] && clr[g] && !ev[g]) |=> !status[g]);
  end

  // R7: an unread word is replaced and overflow is flagged
  a_r7_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && unread) |=> ((rx_hold == $past(rx_word)) && status[EV_RXO]));

  // R3: the line only drops through a clear or a mask change
  a_r3_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && (clr == '0)) |=> (irq || (ien != $past(ien))));
endmodule

// File: rtl/spis_irq_top.sv
module spis_irq_top
  import spis_pkg::*;
#(
  parameter int TXQ_DEPTH = 16,
  parameter int WORD_W    = 8,
  parameter int REG_W     = 16,
  localparam int LW       = $clog2(TXQ_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic             host_re,
  input  logic [1:0]       host_addr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  input  logic             sclk,
  input  logic             simo,
  input  logic             cs_n,
  output logic             somi,
  output logic             somi_oe,
  output logic             irq
);
  logic              chan_en, fifo_en;
  logic [LW-1:0]     level_raw;
  logic [N_EV-1:0]   ien, status, clr;
  logic              push, rx_read;
  logic [2:0]        sync_q;
  logic              cs_s, simo_s, sclk_s, cs_act;
  logic [WORD_W-1:0] q_head, rx_word, rx_hold;
  logic              q_empty, q_pop, ev_txe, ev_txu, rx_done;
  logic              unused_ok;

  assign unused_ok = ^host_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en   <= 1'b0;
      fifo_en   <= 1'b0;
      level_raw <= '0;
      ien       <= '0;
    end else if (host_we) begin
      if (host_addr == REG_CTRL) begin
        chan_en   <= host_wdata[CTL_CHAN];
        fifo_en   <= host_wdata[CTL_QUEUE];
        level_raw <= host_wdata[CTL_LVL_LSB +: LW];
      end
      if (host_addr == REG_IEN) ien <= host_wdata[N_EV-1:0];
    end
  end

  assign clr     = (host_we && (host_addr == REG_STAT)) ? host_wdata[N_EV-1:0] : '0;
  assign push    = host_we && (host_addr == REG_DATA);
  assign rx_read = host_re && (host_addr == REG_DATA);

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      REG_CTRL: begin
        host_rdata[CTL_CHAN]          = chan_en;
        host_rdata[CTL_QUEUE]         = fifo_en;
        host_rdata[CTL_LVL_LSB +: LW] = level_raw;
      end
      REG_IEN:  host_rdata[N_EV-1:0]   = ien;
      REG_STAT: host_rdata[N_EV-1:0]   = status;
      default:  host_rdata[WORD_W-1:0] = rx_hold;
    endcase
  end

  spis_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d ({cs_n, simo, sclk}),
    .q (sync_q)
  );
  assign cs_s    = sync_q[2];
  assign simo_s  = sync_q[1];
  assign sclk_s  = sync_q[0];
  assign cs_act  = chan_en & ~cs_s;
  assign somi_oe = cs_act;

  spis_txq #(.DEPTH(TXQ_DEPTH), .DW(WORD_W)) u_txq (
    .clk (clk),
    .rst_n (rst_n),
    .chan_en (chan_en),
    .fifo_en (fifo_en),
    .level_raw (level_raw),
    .push (push),
    .push_data (host_wdata[WORD_W-1:0]),
    .pop (q_pop),
    .head (q_head),
    .empty (q_empty),
    .ev_txe (ev_txe)
  );

  spis_shift #(.DW(WORD_W)) u_shift (
    .clk (clk),
    .rst_n (rst_n),
    .cs_act (cs_act),
    .sclk_s (sclk_s),
    .simo_s (simo_s),
    .q_head (q_head),
    .q_empty (q_empty),
    .q_pop (q_pop),
    .somi (somi),
    .rx_done (rx_done),
    .rx_word (rx_word),
    .ev_txu (ev_txu)
  );

  spis_evt #(.DW(WORD_W), .NE(N_EV)) u_evt (
    .clk (clk),
    .rst_n (rst_n),
    .ev_txe (ev_txe),
    .ev_txu (ev_txu),
    .rx_done (rx_done),
    .rx_word (rx_word),
    .rx_read (rx_read),
    .clr (clr),
    .ien (ien),
    .status (status),
    .rx_hold (rx_hold),
    .irq (irq)
  );
endmodule

// File: tb/spis_irq_top_bench.sv
module spis_irq_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic        host_re = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = '0;
  wire  [15:0] host_rdata;
  logic        sclk = 1'b0;
  logic        simo = 1'b0;
  logic        cs_n = 1'b1;
  wire         somi, somi_oe, irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m_tx [20];
  logic [7:0] m_rx [20];
  logic [7:0] exp_rx [20];
  logic [7:0] mq [$];
  int cap_m = 1;
  logic [15:0] rv;

  spis_irq_top u_spis_irq_top (
    .clk (clk), .rst_n (rst_n), .host_we (host_we), .host_re (host_re),
    .host_addr (host_addr), .host_wdata (host_wdata), .host_rdata (host_rdata),
    .sclk (sclk), .simo (simo), .cs_n (cs_n), .somi (somi),
    .somi_oe (somi_oe), .irq (irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [15:0] ctrl_word(input bit ch, input bit qe, input int lvl);
    logic [15:0] w;
    w = '0;
    w[0] = ch;
    w[1] = qe;
    w[8:4] = 5'(lvl);
    return w;
  endfunction

  task automatic report_and_end();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hr(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    host_re = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_re = 1'b0;
  endtask

  task automatic model_push(input logic [7:0] b);
    hw(2'd3, {8'h00, b});
    if (mq.size() < cap_m) mq.push_back(b);
  endtask

  task automatic plan_burst(input int n);
    for (int k = 0; k < n; k++) begin
      m_tx[k] = 8'($urandom);
      if (mq.size() > 0) exp_rx[k] = mq.pop_front();
      else exp_rx[k] = 8'h00;
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic spi_burst(input int n);
    @(negedge clk);
    cs_n = 1'b0;
    half();
    for (int k = 0; k < n; k++) begin
      for (int i = 7; i >= 0; i--) begin
        simo = m_tx[k][i];
        half();
        if (k == 0 && i == 7) chk("R5 somi_oe while selected", {15'd0, somi_oe}, 16'd1);
        m_rx[k][i] = somi;
        sclk = 1'b1;
        half();
        if (!(k == n - 1 && i == 0)) sclk = 1'b0;
      end
    end
    cs_n = 1'b1;
    half();
    sclk = 1'b0;
    half();
    half();
    chk("R5 somi_oe after deselect", {15'd0, somi_oe}, 16'd0);
  endtask

  task automatic cmp_burst(input string tag, input int n);
    for (int k = 0; k < n; k++) chk(tag, {8'h00, m_rx[k]}, {8'h00, exp_rx[k]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    report_and_end();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    hr(2'd2, rv); chk("R1 status after reset", rv, 16'h0000);
    hr(2'd0, rv); chk("R1 control after reset", rv, 16'h0000);
    chk("R1 irq after reset", {15'd0, irq}, 16'd0);
    chk("R1 somi_oe after reset", {15'd0, somi_oe}, 16'd0);

    // R2 single-register mode: enabling raises transmit-empty
    hw(2'd0, ctrl_word(1, 0, 1));
    hr(2'd2, rv); chk("R2 txe on enable", rv, 16'h0001);
    chk("R3 irq masked", {15'd0, irq}, 16'd0);
    hw(2'd1, 16'h000F);
    chk("R3 irq with enable", {15'd0, irq}, 16'd1);
    hw(2'd2, 16'h0001);
    hr(2'd2, rv); chk("R4 clear loses to live source", rv, 16'h0001);

    // R3 load removes source, line stays until clear
    model_push(8'hA5);
    hr(2'd2, rv); chk("R3 status kept after load", rv, 16'h0001);
    chk("R3 irq kept after load", {15'd0, irq}, 16'd1);
    hw(2'd2, 16'h0001);
    hr(2'd2, rv); chk("R4 clear drops bit", rv, 16'h0000);
    chk("R3 irq drops after clear", {15'd0, irq}, 16'd0);
    model_push(8'h3C); // R9 dropped: single register already full

    // R8 R9 two words: loaded byte then zero fill
    plan_burst(2);
    spi_burst(2);
    cmp_burst("R9 R8 single-register burst", 2);
    hr(2'd2, rv); chk("R7 R8 all events", rv, 16'h000F);
    hr(2'd3, rv); chk("R7 newest word kept", rv, {8'h00, m_tx[1]});
    hw(2'd2, 16'h000F);
    hr(2'd2, rv); chk("R4 only live txe remains", rv, 16'h0001);

    // R6 single word with data read earlier
    model_push(8'h5A);
    hw(2'd2, 16'h000F);
    hr(2'd2, rv); chk("R4 cleared after load", rv, 16'h0000);
    plan_burst(1);
    spi_burst(1);
    cmp_burst("R5 word out", 1);
    hr(2'd2, rv); chk("R6 receive full no overflow", rv, 16'h0005);
    hr(2'd3, rv); chk("R6 received word", rv, {8'h00, m_tx[0]});
    hw(2'd2, 16'h000F);

    // R2 disabled channel keeps transmit-empty quiet
    hw(2'd0, 16'h0000);
    hw(2'd2, 16'h000F);
    hr(2'd2, rv); chk("R2 no txe when disabled", rv, 16'h0000);

    // R10 R11 queue mode, level 4
    cap_m = 16;
    hw(2'd0, ctrl_word(1, 1, 4));
    hr(2'd0, rv); chk("R1 control readback", rv, ctrl_word(1, 1, 4));
    hr(2'd2, rv); chk("R10 watermark event", rv, 16'h0001);
    hw(2'd2, 16'h000F);
    hr(2'd2, rv); chk("R11 no rearm without writes", rv, 16'h0000);
    for (int j = 0; j < 3; j++) model_push(8'($urandom));
    hr(2'd2, rv); chk("R11 no rearm after level-1 writes", rv, 16'h0000);
    model_push(8'($urandom));
    hr(2'd2, rv); chk("R11 rearm after level writes", rv, 16'h0001);
    hw(2'd2, 16'h000F);
    plan_burst(4);
    spi_burst(4);
    cmp_burst("R9 queue order", 4);
    hr(2'd2, rv); chk("R11 quiet while disarmed", rv, 16'h000C);
    hr(2'd3, rv); chk("R7 last word", rv, {8'h00, m_tx[3]});
    hw(2'd2, 16'h000F);

    // R9 R10 full queue, level 16, one extra write dropped
    hw(2'd0, ctrl_word(1, 1, 16));
    for (int j = 0; j < 17; j++) model_push(8'($urandom));
    hr(2'd2, rv); chk("R10 no event without space", rv, 16'h0000);
    plan_burst(17);
    spi_burst(17);
    cmp_burst("R9 R8 full queue drain", 17);
    hr(2'd2, rv); chk("R10 event once drained", rv, 16'h000F);
    hr(2'd3, rv);
    hw(2'd2, 16'h000F);

    // R5 R9 random traffic against the queue model
    for (int it = 0; it < 6; it++) begin
      int lv, np, nb;
      lv = 1 + int'($urandom % 8);
      np = int'($urandom % 7);
      nb = 1 + int'($urandom % 6);
      hw(2'd0, ctrl_word(1, 1, lv));
      for (int j = 0; j < np; j++) model_push(8'($urandom));
      plan_burst(nb);
      spi_burst(nb);
      cmp_burst("R5 R9 random burst", nb);
      hr(2'd3, rv); chk("R6 random receive", rv, {8'h00, m_tx[nb-1]});
      hw(2'd2, 16'h000F);
    end

    report_and_end();
  end
endmodule